// File: doc/BRIEF.md
# Working-Register File Execute Unit

This block is the data side of a small 8-bit processor core. It holds an 8-bit working register and a byte-wide data memory, and it executes one 16-bit instruction word in each cycle that `instr_valid` is high. The supported instructions are literal loads and adds, a store from the working register, four byte-oriented read-modify-write operations, a bank-select load and a two-word memory-to-memory copy. Program sequencing and branching are not part of the block. Whenever an arithmetic or logic result is produced, the block registers that result and its carry information for an external status-flag unit.

Each operand field is an 8-bit offset. When the instruction's bank bit is 0, the offset is mapped onto a 256-byte quick-access window. The lower half of that window reaches the bottom 128 bytes of memory, and the upper half reaches the top 128 bytes. When the bank bit is 1, the offset is prefixed with a 4-bit bank register. Byte-oriented operations carry a destination bit that sends the result either to the working register or back to the memory byte that was read.

Top module: `wreg_exec_unit`

## Requirements
- R1: After reset the working register, the bank register and every memory byte read as 00h, and `res_valid` is low.
- R2: A word 0000 1110 kkkkkkkk loads k into the working register one cycle later and raises no result strobe.
- R3: A word 0000 1111 kkkkkkkk sets the working register to (W+k) mod 256. The following cycle shows `res_valid`=1, `res_value` equal to the sum, `res_carry` equal to the bit-8 carry and `res_dcarry` equal to the carry out of bit 3.
- R4: A word 0110 111a ffffffff stores the working register into the addressed byte and leaves the working register unchanged. It raises no result strobe.
- R5: With bank bit (bit 8) at 0, offsets 00h–7Fh address bytes 000h–07Fh, and offsets 80h–FFh address bytes F80h–FFFh.
- R6: A word 0000 0001 0000 kkkk loads k into the bank register. With bank bit 1, the address is {bank, offset}.
- R7: For byte-oriented operations, bit 9 (d) selects the destination. d=0 writes the result to the working register and leaves memory alone. d=1 writes the result to the addressed byte and leaves the working register alone.
- R8: A word 0010 01da ffffffff computes W+f and produces carry and digit carry in the same way as R3.
- R9: A word 0001 11da ffffffff computes the bitwise inverse of f. Both carry outputs are 0.
- R10: A word 0000 01da ffffffff computes f−1. `res_carry` is 1 when f≠0 (no borrow), and `res_dcarry` is 1 when f[3:0]≠0.
- R11: A word 0101 00da ffffffff produces f. With d=1 the byte is unchanged, the working register is unchanged, and the result strobe still fires with the value of f.
- R12: A word 1100 ssss(12) followed by the next valid word 1111 dddd(12) copies byte s to byte d. The working register does not change and no result strobe is raised. If the next valid word does not begin with 1111, it is consumed and nothing is copied.
- R13: Any word matching none of the patterns above, including a lone 1111 word and a 0000 0001 word whose bits 7:4 are not zero, changes nothing and raises no result strobe. A cycle with `instr_valid` low also changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word |
| wreg | output | 8 | Working register contents |
| res_valid | output | 1 | A result was produced by the previous instruction |
| res_value | output | 8 | Result byte for the flag unit |
| res_carry | output | 1 | Carry (add) or no-borrow (decrement) |
| res_dcarry | output | 1 | Carry out of bit 3, or no-borrow from the low nibble |

## Verification
In a single cycle, one instruction can read a memory byte, combine it with the working register and write the result back to that same byte. The working register can also be both an operand and the destination. The stimulus draws operand offsets from a small pool that includes both window edges, so random read-modify-write, store and copy operations often hit the same byte in consecutive cycles, and a copy can have the same byte as source and destination. After every instruction, the bench compares the working register and the result outputs against a bench-side memory model. Memory contents come back through later reads into the working register.

// File: rtl/wreg_exec_pkg.sv
package wreg_exec_pkg;
   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      OP_NOP,
      OP_LDLIT,
      OP_ADDLIT,
      OP_STORE,
      OP_SETBANK,
      OP_ADDF,
      OP_INVF,
      OP_DECRF,
      OP_PASSF,
      OP_COPY_SRC,
      OP_COPY_DST
   } op_e;

   typedef struct packed {
      op_e              op;
      logic             to_file;
      logic             banked;
      logic [BYTE_W-1:0] low;
   } dec_t;
endpackage

// File: rtl/wx_decode.sv
module wx_decode
   import wreg_exec_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   input  logic              second_due,
   output dec_t              dec
);
   always_comb begin
      dec.op      = OP_NOP;
      dec.to_file = word[9];
      dec.banked  = word[8];
      dec.low     = word[7:0];
      if (second_due) begin
         if (word[15:12] == 4'hF) dec.op = OP_COPY_DST;
      end else begin
         casez (word[15:8])
            8'h0E:       dec.op = OP_LDLIT;
            8'h0F:       dec.op = OP_ADDLIT;
            8'b0110_111?: dec.op = OP_STORE;
            8'h01:       if (word[7:4] == 4'h0) dec.op = OP_SETBANK;
            8'b0010_01??: dec.op = OP_ADDF;
            8'b0001_11??: dec.op = OP_INVF;
            8'b0000_01??: dec.op = OP_DECRF;
            8'b0101_00??: dec.op = OP_PASSF;
            8'b1100_????: dec.op = OP_COPY_SRC;
            default:     dec.op = OP_NOP;
         endcase
      end
   end
endmodule

// File: rtl/wx_addr.sv
module wx_addr #(
   parameter int ADDR_W = 12,
   localparam int BANK_W = ADDR_W - 8
) (
   input  logic [7:0]        offset,
   input  logic              banked,
   input  logic [BANK_W-1:0] bank,
   output logic [ADDR_W-1:0] ea
);
   logic [BANK_W-1:0] quick_hi;

   assign quick_hi = offset[7] ? {BANK_W{1'b1}} : {BANK_W{1'b0}};
   assign ea       = banked ? {bank, offset} : {quick_hi, offset};
endmodule

// File: rtl/wx_alu.sv
module wx_alu
   import wreg_exec_pkg::*;
(
   input  op_e              op,
   input  logic [BYTE_W-1:0] w,
   input  logic [BYTE_W-1:0] f,
   input  logic [BYTE_W-1:0] lit,
   output logic [BYTE_W-1:0] res,
   output logic              carry,
   output logic              dcarry,
   output logic              produces
);
   logic [BYTE_W-1:0] addend;
   logic [BYTE_W:0]   sum;
   logic [4:0]        nib;

   assign addend = (op == OP_ADDLIT) ? lit : f;
   assign sum    = {1'b0, w} + {1'b0, addend};
   assign nib    = {1'b0, w[3:0]} + {1'b0, addend[3:0]};

   always_comb begin
      res      = '0;
      carry    = 1'b0;
      dcarry   = 1'b0;
      produces = 1'b1;
      unique case (op)
         OP_ADDLIT, OP_ADDF: begin
            res    = sum[BYTE_W-1:0];
            carry  = sum[BYTE_W];
            dcarry = nib[4];
         end
         OP_INVF:  res = ~f;
         OP_DECRF: begin
            res    = f - 8'd1;
            carry  = |f;
            dcarry = |f[3:0];
         end
         OP_PASSF: res = f;
         default:  produces = 1'b0;
      endcase
   end
endmodule

// File: rtl/wx_ram.sv
module wx_ram #(
   parameter int ADDR_W         = 12,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              we,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data
);
   logic [7:0] mem [DEPTH];

   assign rd_data = mem[rd_addr];

   generate
      if (CLEAR_ON_RESET) begin : g_cleared
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[wr_addr] <= wr_data;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[wr_addr] <= wr_data;
         end
      end
   endgenerate
endmodule

// File: rtl/wreg_exec_unit.sv
module wreg_exec_unit
   import wreg_exec_pkg::*;
#(
   parameter int ADDR_W         = 12,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        instr_valid,
   input  logic [15:0] instr,
   output logic [7:0]  wreg,
   output logic        res_valid,
   output logic [7:0]  res_value,
   output logic        res_carry,
   output logic        res_dcarry
);
   localparam int BANK_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 12) begin : g_bad_addr_w
         $error("wreg_exec_unit: ADDR_W must lie in 9..12");
      end
   endgenerate

   logic [7:0]        w_q;
   logic [BANK_W-1:0] bsr_q;
   logic              pend_q;
   logic [ADDR_W-1:0] src_q;

   dec_t              dec;
   logic [ADDR_W-1:0] ea;
   logic [ADDR_W-1:0] rd_addr;
   logic [7:0]        rd_data;
   logic [7:0]        alu_res;
   logic              alu_c, alu_dc, alu_prod;
   logic              is_fop;
   logic              ram_we;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0]        wr_data;

   wx_decode u_dec (
      .word       (instr),
      .second_due (pend_q),
      .dec        (dec)
   );

   wx_addr #(.ADDR_W(ADDR_W)) u_addr (
      .offset (dec.low),
      .banked (dec.banked),
      .bank   (bsr_q),
      .ea     (ea)
   );

   assign rd_addr = pend_q ? src_q : ea;

   wx_ram #(.ADDR_W(ADDR_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .we      (ram_we),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   wx_alu u_alu (
      .op       (dec.op),
      .w        (w_q),
      .f        (rd_data),
      .lit      (dec.low),
      .res      (alu_res),
      .carry    (alu_c),
      .dcarry   (alu_dc),
      .produces (alu_prod)
   );

   assign is_fop = (dec.op == OP_ADDF) || (dec.op == OP_INVF) ||
                   (dec.op == OP_DECRF) || (dec.op == OP_PASSF);

   always_comb begin
      ram_we  = 1'b0;
      wr_addr = ea;
      wr_data = alu_res;
      if (instr_valid) begin
         if (dec.op == OP_STORE) begin
            ram_we  = 1'b1;
            wr_data = w_q;
         end else if (dec.op == OP_COPY_DST) begin
            ram_we  = 1'b1;
            wr_addr = instr[ADDR_W-1:0];
            wr_data = rd_data;
         end else if (is_fop && dec.to_file) begin
            ram_we  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q        <= '0;
         bsr_q      <= '0;
         pend_q     <= 1'b0;
         src_q      <= '0;
         res_valid  <= 1'b0;
         res_value  <= '0;
         res_carry  <= 1'b0;
         res_dcarry <= 1'b0;
      end else begin
         res_valid <= instr_valid && alu_prod;
         if (instr_valid) begin
            if (pend_q) pend_q <= 1'b0;
            if (alu_prod) begin
               res_value  <= alu_res;
               res_carry  <= alu_c;
               res_dcarry <= alu_dc;
            end
            case (dec.op)
               OP_LDLIT:    w_q   <= dec.low;
               OP_ADDLIT:   w_q   <= alu_res;
               OP_SETBANK:  bsr_q <= dec.low[BANK_W-1:0];
               OP_COPY_SRC: begin
                  pend_q <= 1'b1;
                  src_q  <= instr[ADDR_W-1:0];
               end
               default: if (is_fop && !dec.to_file) w_q <= alu_res;
            endcase
         end
      end
   end

   assign wreg = w_q;
endmodule

// File: rtl/wreg_exec_unit_chk.sv
module wreg_exec_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        instr_valid,
   input logic [15:0] instr,
   input logic [7:0]  wreg,
   input logic        res_valid,
   input logic [7:0]  res_value,
   input logic        pend
);
   assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> !res_valid && $stable(wreg));

   assert_load_literal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !pend && instr[15:8] == 8'h0E)
      |=> (wreg == $past(instr[7:0])) && !res_valid);

   assert_add_literal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !pend && instr[15:8] == 8'h0F)
      |=> res_valid && (res_value == 8'($past(wreg) + $past(instr[7:0]))) && (wreg == res_value));

   assert_store_keeps_w_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !pend && instr[15:9] == 7'b0110111)
      |=> $stable(wreg) && !res_valid);

   assert_pass_to_file_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !pend && instr[15:9] == 7'b0101001)
      |=> $stable(wreg) && res_valid);

   assert_copy_second_word_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> $stable(wreg) && !res_valid);
endmodule

bind wreg_exec_unit wreg_exec_unit_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr       (instr),
   .wreg        (wreg),
   .res_valid   (res_valid),
   .res_value   (res_value),
   .pend        (pend_q)
);

// File: tb/tb_wreg_exec_unit.sv
module tb_wreg_exec_unit;
   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 3000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr = 16'h0000;
   logic [7:0]  wreg;
   logic        res_valid;
   logic [7:0]  res_value;
   logic        res_carry;
   logic        res_dcarry;

   wreg_exec_unit dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .instr_valid(instr_valid),
      .instr      (instr),
      .wreg       (wreg),
      .res_valid  (res_valid),
      .res_value  (res_value),
      .res_carry  (res_carry),
      .res_dcarry (res_dcarry)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0]  m_mem [4096];
   logic [7:0]  m_w = 8'h00;
   logic [3:0]  m_bsr = 4'h0;
   bit          m_pend = 1'b0;
   logic [11:0] m_src = 12'h000;
   logic        exp_rv;
   logic [7:0]  exp_val;
   logic        exp_c, exp_dc;

   function automatic logic [11:0] map_ea(input logic a, input logic [7:0] off, input logic [3:0] b);
      if (a) return {b, off};
      return off[7] ? {4'hF, off} : {4'h0, off};
   endfunction

   function automatic string req_for(input logic [15:0] word, input bit pend);
      if (pend) return "R12";
      casez (word[15:8])
         8'h0E:        return "R2";
         8'h0F:        return "R3";
         8'b0110_111?: return "R4";
         8'h01:        return (word[7:4] == 4'h0) ? "R6" : "R13";
         8'b0010_01??: return "R8";
         8'b0001_11??: return "R9";
         8'b0000_01??: return "R10";
         8'b0101_00??: return "R11";
         8'b1100_????: return "R12";
         default:      return "R13";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %02h expected %02h at %0t", req, what, act, expv, $time);
      end
   endtask

   task automatic model(input logic [15:0] word);
      logic [11:0] adr;
      logic [7:0]  f, r;
      logic [8:0]  s;
      bit          fop;
      adr = map_ea(word[8], word[7:0], m_bsr);
      f = m_mem[adr];
      exp_rv = 1'b0; exp_val = 8'h00; exp_c = 1'b0; exp_dc = 1'b0;
      fop = 1'b0; r = 8'h00;
      if (m_pend) begin
         m_pend = 1'b0;
         if (word[15:12] == 4'hF) m_mem[word[11:0]] = m_mem[m_src];
      end else begin
         casez (word[15:8])
            8'h0E: m_w = word[7:0];
            8'h0F: begin
               s = {1'b0, m_w} + {1'b0, word[7:0]};
               exp_rv = 1'b1; exp_val = s[7:0]; exp_c = s[8];
               exp_dc = ({1'b0, m_w[3:0]} + {1'b0, word[3:0]}) > 5'd15;
               m_w = s[7:0];
            end
            8'b0110_111?: m_mem[adr] = m_w;
            8'h01: if (word[7:4] == 4'h0) m_bsr = word[3:0];
            8'b0010_01??: begin
               s = {1'b0, m_w} + {1'b0, f};
               r = s[7:0]; exp_c = s[8];
               exp_dc = ({1'b0, m_w[3:0]} + {1'b0, f[3:0]}) > 5'd15;
               fop = 1'b1;
            end
            8'b0001_11??: begin r = ~f; fop = 1'b1; end
            8'b0000_01??: begin
               r = f - 8'd1; exp_c = (f != 8'h00); exp_dc = (f[3:0] != 4'h0); fop = 1'b1;
            end
            8'b0101_00??: begin r = f; fop = 1'b1; end
            8'b1100_????: begin m_pend = 1'b1; m_src = word[11:0]; end
            default: ;
         endcase
         if (fop) begin
            exp_rv = 1'b1; exp_val = r;
            if (word[9]) m_mem[adr] = r;
            else         m_w = r;
         end
      end
   endtask

   task automatic issue(input logic [15:0] word, input string req);
      string r;
      r = (req == "") ? req_for(word, m_pend) : req;
      instr = word;
      instr_valid = 1'b1;
      model(word);
      @(negedge clk);
      chk(r, "wreg", wreg, m_w);
      chk(r, "res_valid", {7'b0, res_valid}, {7'b0, exp_rv});
      if (exp_rv) begin
         chk(r, "res_value", res_value, exp_val);
         chk(r, "res_carry", {7'b0, res_carry}, {7'b0, exp_c});
         chk(r, "res_dcarry", {7'b0, res_dcarry}, {7'b0, exp_dc});
      end
   endtask

   task automatic idle();
      instr_valid = 1'b0;
      instr = $urandom();
      @(negedge clk);
      chk("R13", "idle res_valid", {7'b0, res_valid}, 8'h00);
      chk("R13", "idle wreg", wreg, m_w);
   endtask

   function automatic logic [7:0] pick_off();
      case ($urandom_range(0, 6))
         0: return 8'h00;
         1: return 8'h01;
         2: return 8'h7F;
         3: return 8'h80;
         4: return 8'h81;
         5: return 8'hFF;
         default: return 8'($urandom());
      endcase
   endfunction

   function automatic logic [11:0] pick_addr();
      case ($urandom_range(0, 5))
         0: return 12'h000;
         1: return 12'h07F;
         2: return 12'hF80;
         3: return 12'hFFF;
         4: return {4'($urandom_range(0, 15)), pick_off()};
         default: return 12'h001;
      endcase
   endfunction

   task automatic random_op();
      logic [7:0] off;
      logic       a, d;
      off = pick_off();
      a = 1'($urandom());
      d = 1'($urandom());
      case ($urandom_range(0, 10))
         0: issue({8'h0E, 8'($urandom())}, "");
         1: issue({8'h0F, 8'($urandom())}, "");
         2: issue({7'b0110111, a, off}, "");
         3: issue({8'h01, 4'h0, 4'($urandom_range(0, 15))}, "");
         4: issue({6'b001001, d, a, off}, "");
         5: issue({6'b000111, d, a, off}, "");
         6: issue({6'b000001, d, a, off}, "");
         7: issue({6'b010100, d, a, off}, "");
         8: begin
            issue({4'hC, pick_addr()}, "");
            if ($urandom_range(0, 3) == 0) idle();
            if ($urandom_range(0, 7) == 0) issue({8'h0E, 8'($urandom())}, "R12");
            else                           issue({4'hF, pick_addr()}, "R12");
         end
         9: begin
            case ($urandom_range(0, 3))
               0: issue(16'h0000, "R13");
               1: issue(16'hFFFF, "R13");
               2: issue(16'h0135, "R13");
               default: issue(16'h8000, "R13");
            endcase
         end
         default: idle();
      endcase
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2011));
      for (int i = 0; i < 4096; i++) m_mem[i] = 8'h00;

      repeat (3) @(negedge clk);
      chk("R1", "wreg in reset", wreg, 8'h00);
      chk("R1", "res_valid in reset", {7'b0, res_valid}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      issue(16'h5000, "R1");
      issue(16'h507F, "R1");
      issue(16'h5080, "R1");
      issue(16'h50FF, "R1");
      issue(16'h5123, "R1");

      issue(16'h0E38, "R2");
      issue(16'h0F2F, "R3");
      issue(16'h0E9C, "R2");
      issue(16'h0F64, "R3");

      issue(16'h0E5A, "R2");
      issue(16'h6E85, "R5");
      issue(16'h010F, "R6");
      issue(16'h0E00, "R2");
      issue(16'h5185, "R5");
      issue(16'h0E11, "R2");
      issue(16'h6E10, "R5");
      issue(16'h0100, "R6");
      issue(16'h0E00, "R2");
      issue(16'h5110, "R6");

      issue(16'h0E07, "R2");
      issue(16'h2610, "R7");
      issue(16'h5010, "R8");
      issue(16'h0620, "R10");
      issue(16'h5020, "R10");
      issue(16'h1E20, "R9");
      issue(16'h1C10, "R9");
      issue(16'h5210, "R11");
      issue(16'h0E00, "R2");
      issue(16'h5010, "R7");

      issue(16'hCF85, "R12");
      issue(16'hF030, "R12");
      issue(16'h5030, "R12");
      issue(16'hFF30, "R13");
      issue(16'h0145, "R13");
      idle();

      for (int n = 0; n < N_RANDOM; n++) random_op();

      for (int b = 0; b < 16; b++) begin
         issue({8'h01, 4'h0, 4'(b)}, "R6");
         issue(16'h5100, "R12");
         issue(16'h517F, "R12");
         issue(16'h5180, "R12");
         issue(16'h51FF, "R12");
      end

      instr_valid = 1'b0;
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule